// File: doc/BRIEF.md
# Serial NOR Flash Block-Protect Unit

This block holds the protection part of a serial NOR flash status register and gates program operations against it. A decoded status-write strobe loads a new status byte, a decoded status-read strobe captures the byte for read-back, and every program request returns a registered allow or deny verdict one cycle later.

The protected region is a power-of-two number of sectors. A four-bit protect level selects the size, and a top/bottom selector anchors the region at the high or the low end of the array. Parameters set the sector size, the sector count, the program-address width, and whether the top/bottom bit and the fourth protect bit exist. When a feature is absent, its status bit is ignored on write, reads back as 0 and counts as 0 in the protect level.

The write-enable latch is kept outside this block and arrives as an input, so it can be reported in the read-back byte.

Top module: `flash_bp_unit`

## Requirements
- R1: A status write loads protect bits 0..2 from data bits 2, 3 and 4 and the status-write-disable flag from data bit 7. A later status read returns them at the same positions.
- R2: Read-back byte layout:
  - bit 1 is the write-enable input sampled with the read strobe;
  - bit 0 is 0;
  - `status_o` changes one cycle after `rd_stat_i` and holds its value between reads.
- R3: With `HAS_TB`=1, data bit 5 is stored as the top/bottom selector and read back at bit 5. With `HAS_TB`=0, bit 5 is ignored on write, reads as 0, and the selector acts as 0.
- R4: With `HAS_BP3`=1, data bit 6 is stored as protect bit 3 and read back at bit 6. With `HAS_BP3`=0, bit 6 is ignored, reads as 0, and the protect level runs only from 0 to 7.
- R5: With protect level L = {bit3,bit2,bit1,bit0} equal to 0, every program is allowed.
- R6: The sector index of a program is its address divided by `SECTOR_BYTES`. With L>0 and the selector at 0, a program is denied when index + 2^(L-1) >= `SECTOR_COUNT`.
- R7: With L>0 and the selector at 1, a program is denied when index < 2^(L-1).
- R8: When 2^(L-1) is at least `SECTOR_COUNT`, every program is denied, and the count never wraps to a small value.
- R9: A program request produces, in the following cycle, a one-cycle `prog_done_o` together with exactly one of `prog_ok_o` and `prog_err_o`. All three are low in every other cycle.
- R10: Reset clears all protect bits, the selector and the write-disable flag. `status_o` reads 0 after reset.
- R11: A program request in the same cycle as a status write is judged against the protection state from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stat_i | input | 1 | Decoded status-write strobe |
| wr_data_i | input | 8 | Status byte to load |
| rd_stat_i | input | 1 | Decoded status-read strobe |
| wel_i | input | 1 | Current write-enable latch |
| status_o | output | 8 | Captured read-back status byte |
| prog_req_i | input | 1 | Program request strobe |
| prog_addr_i | input | ADDR_W | Byte address of the program request |
| prog_done_o | output | 1 | Verdict valid (one cycle) |
| prog_ok_o | output | 1 | Program allowed |
| prog_err_o | output | 1 | Program denied (error pulse) |

## Verification
The bench drives two instances in parallel: one with every feature present and one without the top/bottom and fourth protect bits.

The bench targets these corner cases:
- **Boundary sectors of a protected region.** It programs the last unprotected sector and the first protected one in both anchors. An off-by-one in the bound comparison flips one of those verdicts.
- **Protect levels whose count reaches or exceeds the sector count.** If the count computation wraps, the whole-array protection reopens at level 15.
- **Feature bits on the reduced instance.** It sets bits 5 and 6 there. A design that stored them would read them back and move or enlarge the region.
- **Program in the same cycle as a status write.** A design that used the new state early would give the wrong verdict.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

    localparam int WEL_POS   = 1;
    localparam int BPLO_POS  = 2;
    localparam int TB_POS    = 5;
    localparam int BP3_POS   = 6;
    localparam int SRWD_POS  = 7;

    typedef struct packed {
        logic       wr_lock;   // status-write-disable flag
        logic       anchor_lo; // 1: region at low sectors
        logic [3:0] level;     // protect level
    } prot_state_t;

    typedef enum logic [1:0] {
        VERDICT_IDLE  = 2'd0,
        VERDICT_ALLOW = 2'd1,
        VERDICT_DENY  = 2'd2
    } verdict_e;

    // Protected sector count, clamped to limit so it never wraps.
    function automatic logic [31:0] sat_count(input logic [3:0] level,
                                              input logic [31:0] limit);
        logic [31:0] raw;
        logic [4:0]  shamt;
        if (level == 4'd0) begin
            return 32'd0;
        end
        shamt = {1'b0, level} - 5'd1;
        if (shamt >= 5'd31) begin
            return limit;
        end
        raw = 32'd1 << shamt;
        return (raw > limit) ? limit : raw;
    endfunction

    function automatic logic [7:0] pack_status(input prot_state_t st,
                                               input logic wel);
        logic [7:0] b;
        b = 8'd0;
        b[WEL_POS]             = wel;
        b[BPLO_POS +: 3]       = st.level[2:0];
        b[TB_POS]              = st.anchor_lo;
        b[BP3_POS]             = st.level[3];
        b[SRWD_POS]            = st.wr_lock;
        return b;
    endfunction

endpackage

// File: rtl/fbp_status_reg.sv
module fbp_status_reg
    import fbp_pkg::*;
#(
    parameter bit HAS_TB  = 1'b1,
    parameter bit HAS_BP3 = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output prot_state_t state_o
);

    prot_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.wr_lock     <= 1'b0;
            st_q.level[2:0]  <= 3'd0;
        end else if (wr_en) begin
            st_q.wr_lock     <= wr_data[SRWD_POS];
            st_q.level[2:0]  <= wr_data[BPLO_POS +: 3];
        end
    end

    generate
        if (HAS_TB) begin : g_tb
            always_ff @(posedge clk) begin
                if (rst)        st_q.anchor_lo <= 1'b0;
                else if (wr_en) st_q.anchor_lo <= wr_data[TB_POS];
            end
        end else begin : g_no_tb
            always_ff @(posedge clk) st_q.anchor_lo <= 1'b0;
        end

        if (HAS_BP3) begin : g_bp3
            always_ff @(posedge clk) begin
                if (rst)        st_q.level[3] <= 1'b0;
                else if (wr_en) st_q.level[3] <= wr_data[BP3_POS];
            end
        end else begin : g_no_bp3
            always_ff @(posedge clk) st_q.level[3] <= 1'b0;
        end
    endgenerate

    assign state_o = st_q;

    // R1: low protect bits follow the written byte
    a_r1_level_load: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> state_o.level[2:0] == $past(wr_data[4:2]));

    // R1: write-disable flag follows bit 7
    a_r1_lock_load: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> state_o.wr_lock == $past(wr_data[7]));

    // R1: state holds without a write
    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en && !$past(rst) |=> $stable(state_o));

endmodule

// File: rtl/fbp_region_calc.sv
module fbp_region_calc
    import fbp_pkg::*;
#(
    parameter int SECTOR_BYTES = 65536,
    parameter int SECTOR_COUNT = 512,
    parameter int ADDR_W       = 25
) (
    input  prot_state_t         state_i,
    input  logic [ADDR_W-1:0]   addr_i,
    output logic [63:0]         sector_o,
    output logic                deny_o
);

    localparam int SEC_SHIFT = $clog2(SECTOR_BYTES);
    localparam logic [31:0] N_SEC = 32'(SECTOR_COUNT);

    logic [31:0] cnt;
    logic [63:0] sec64;
    logic [63:0] sum;
    logic        deny_hi;
    logic        deny_lo;

    always_comb begin
        cnt     = sat_count(state_i.level, N_SEC);
        sec64   = 64'(addr_i >> SEC_SHIFT);
        sum     = sec64 + 64'(cnt);
        deny_hi = sum >= 64'(N_SEC);
        deny_lo = sec64 < 64'(cnt);
        if (state_i.level == 4'd0) begin
            deny_o = 1'b0;
        end else if (state_i.anchor_lo) begin
            deny_o = deny_lo;
        end else begin
            deny_o = deny_hi;
        end
    end

    assign sector_o = sec64;

endmodule

// File: rtl/fbp_prog_gate.sv
module fbp_prog_gate
    import fbp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic deny_i,
    output logic done_o,
    output logic ok_o,
    output logic err_o
);

    verdict_e v_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= VERDICT_IDLE;
        end else if (req_i) begin
            v_q <= deny_i ? VERDICT_DENY : VERDICT_ALLOW;
        end else begin
            v_q <= VERDICT_IDLE;
        end
    end

    assign done_o = (v_q != VERDICT_IDLE);
    assign ok_o   = (v_q == VERDICT_ALLOW);
    assign err_o  = (v_q == VERDICT_DENY);

    // R9: every request yields a verdict next cycle
    a_r9_done_follows: assert property (@(posedge clk) disable iff (rst)
        req_i |=> done_o);

    // R9: no verdict without a request
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> !done_o && !ok_o && !err_o);

    // R9: exactly one of allow / deny with a verdict
    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $onehot({ok_o, err_o}));

endmodule

// File: rtl/fbp_status_read.sv
module fbp_status_read
    import fbp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_en,
    input  logic        wel_i,
    input  prot_state_t state_i,
    output logic [7:0]  status_o
);

    logic [7:0] stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= 8'd0;
        end else if (rd_en) begin
            stat_q <= pack_status(state_i, wel_i);
        end
    end

    assign status_o = stat_q;

    // R2: bit 1 mirrors the latch at the read strobe
    a_r2_wel_bit: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> status_o[1] == $past(wel_i));

    // R2: bit 0 is always 0
    a_r2_bit0_zero: assert property (@(posedge clk) disable iff (rst)
        status_o[0] == 1'b0);

    // R2: held between reads
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en && !$past(rst) |=> $stable(status_o));

endmodule

// File: rtl/flash_bp_unit.sv
module flash_bp_unit
    import fbp_pkg::*;
#(
    parameter int SECTOR_BYTES = 65536,
    parameter int SECTOR_COUNT = 512,
    parameter int ADDR_W       = 25,
    parameter bit HAS_TB       = 1'b1,
    parameter bit HAS_BP3      = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stat_i,
    input  logic [7:0]        wr_data_i,
    input  logic              rd_stat_i,
    input  logic              wel_i,
    output logic [7:0]        status_o,
    input  logic              prog_req_i,
    input  logic [ADDR_W-1:0] prog_addr_i,
    output logic              prog_done_o,
    output logic              prog_ok_o,
    output logic              prog_err_o
);

    prot_state_t st;
    logic        deny;
    logic [63:0] sector;

    fbp_status_reg #(
        .HAS_TB  (HAS_TB),
        .HAS_BP3 (HAS_BP3)
    ) u_sreg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_stat_i),
        .wr_data (wr_data_i),
        .state_o (st)
    );

    fbp_region_calc #(
        .SECTOR_BYTES (SECTOR_BYTES),
        .SECTOR_COUNT (SECTOR_COUNT),
        .ADDR_W       (ADDR_W)
    ) u_region (
        .state_i  (st),
        .addr_i   (prog_addr_i),
        .sector_o (sector),
        .deny_o   (deny)
    );

    fbp_prog_gate u_gate (
        .clk    (clk),
        .rst    (rst),
        .req_i  (prog_req_i),
        .deny_i (deny),
        .done_o (prog_done_o),
        .ok_o   (prog_ok_o),
        .err_o  (prog_err_o)
    );

    fbp_status_read u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_stat_i),
        .wel_i    (wel_i),
        .state_i  (st),
        .status_o (status_o)
    );

    // R5: level 0 never denies
    a_r5_open: assert property (@(posedge clk) disable iff (rst)
        prog_req_i && st.level == 4'd0 |=> prog_ok_o);

    // R6: last sector is denied in high-anchored mode
    a_r6_top_last: assert property (@(posedge clk) disable iff (rst)
        prog_req_i && !st.anchor_lo && st.level != 4'd0 &&
        sector == 64'(SECTOR_COUNT - 1) |=> prog_err_o);

    // R7: sector 0 is denied in low-anchored mode
    a_r7_bottom_first: assert property (@(posedge clk) disable iff (rst)
        prog_req_i && st.anchor_lo && st.level != 4'd0 &&
        sector == 64'd0 |=> prog_err_o);

    // R3 / R4: absent features never read back
    a_r3_r4_absent_bits: assert property (@(posedge clk) disable iff (rst)
        (!HAS_TB -> !status_o[5]) && (!HAS_BP3 -> !status_o[6]));

endmodule

// File: tb/flash_bp_unit_tb_top.sv
module flash_bp_unit_tb_top;

    localparam int SB = 65536;
    localparam int NS = 512;
    localparam int AW = 25;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_stat = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic rd_stat = 1'b0;
    logic wel = 1'b0;
    logic prog_req = 1'b0;
    logic [AW-1:0] prog_addr = '0;

    logic [7:0] stat_f, stat_m;
    logic done_f, ok_f, err_f, done_m, ok_m, err_m;

    int checks = 0;
    int errors = 0;

    // model state: full and reduced instance
    logic [3:0] lv_f = 4'd0, lv_m = 4'd0;
    logic tb_f = 1'b0, lock_f = 1'b0, lock_m = 1'b0;

    always #4 clk = ~clk;

    flash_bp_unit #(.SECTOR_BYTES(SB), .SECTOR_COUNT(NS), .ADDR_W(AW),
                    .HAS_TB(1'b1), .HAS_BP3(1'b1)) dut_i (
        .clk(clk), .rst(rst), .wr_stat_i(wr_stat), .wr_data_i(wr_data),
        .rd_stat_i(rd_stat), .wel_i(wel), .status_o(stat_f),
        .prog_req_i(prog_req), .prog_addr_i(prog_addr),
        .prog_done_o(done_f), .prog_ok_o(ok_f), .prog_err_o(err_f));

    flash_bp_unit #(.SECTOR_BYTES(SB), .SECTOR_COUNT(NS), .ADDR_W(AW),
                    .HAS_TB(1'b0), .HAS_BP3(1'b0)) dut_min_i (
        .clk(clk), .rst(rst), .wr_stat_i(wr_stat), .wr_data_i(wr_data),
        .rd_stat_i(rd_stat), .wel_i(wel), .status_o(stat_m),
        .prog_req_i(prog_req), .prog_addr_i(prog_addr),
        .prog_done_o(done_m), .prog_ok_o(ok_m), .prog_err_o(err_m));

    function automatic bit ref_allow(input logic [3:0] lv, input logic lo,
                                     input longint addr);
        longint cnt, sec;
        if (lv == 4'd0) return 1'b1;
        cnt = longint'(1) << (lv - 1);
        sec = addr / SB;
        if (lo) return !(sec < cnt);
        return !(sec + cnt >= NS);
    endfunction

    function automatic logic [7:0] ref_stat(input logic lock, input logic [3:0] lv,
                                            input logic lo, input logic w);
        return {lock, lv[3], lo, lv[2:0], w, 1'b0};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_status(input logic [7:0] d);
        @(negedge clk);
        wr_stat = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_stat = 1'b0;
        lock_f = d[7]; lv_f = d[6:2]; tb_f = d[5];
        lv_f = {d[6], d[4:2]};
        lock_m = d[7]; lv_m = {1'b0, d[4:2]};
    endtask

    task automatic rd_check(input logic w, input string req);
        logic [7:0] ef, em;
        @(negedge clk);
        rd_stat = 1'b1;
        wel = w;
        @(negedge clk);
        rd_stat = 1'b0;
        wel = ~w;
        ef = ref_stat(lock_f, lv_f, tb_f, w);
        em = ref_stat(lock_m, lv_m, 1'b0, w);
        check(stat_f == ef, req, 32'(stat_f), 32'(ef));
        check(stat_m == em, req, 32'(stat_m), 32'(em));
    endtask

    task automatic prog_check(input longint addr, input string req);
        bit af, am;
        af = ref_allow(lv_f, tb_f, addr);
        am = ref_allow(lv_m, 1'b0, addr);
        @(negedge clk);
        prog_req = 1'b1;
        prog_addr = AW'(addr);
        @(negedge clk);
        prog_req = 1'b0;
        check(done_f && ok_f == af && err_f == !af, req,
              {29'd0, done_f, ok_f, err_f}, {29'd0, 1'b1, af, !af});
        check(done_m && ok_m == am && err_m == !am, req,
              {29'd0, done_m, ok_m, err_m}, {29'd0, 1'b1, am, !am});
        @(negedge clk);
        check(!done_f && !ok_f && !err_f && !done_m, "R9 pulse width",
              {28'd0, done_f, ok_f, err_f, done_m}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240701));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        check(stat_f == 8'd0 && !done_f, "R10 reset", 32'(stat_f), 32'd0);
        rd_check(1'b0, "R10 status after reset");
        prog_check(longint'(NS - 1) * SB, "R10 open after reset");
        rd_check(1'b1, "R2 wel bit");

        // R1: low bits and lock
        wr_status(8'b1001_1100);
        rd_check(1'b0, "R1 load");
        // R6: level 7 top -> 64 sectors protected (448..511)
        prog_check(longint'(447) * SB + SB - 1, "R6 last open sector");
        prog_check(longint'(448) * SB, "R6 first protected sector");
        // R3: bottom anchor on full; ignored on reduced
        wr_status(8'b0010_0100);
        rd_check(1'b1, "R3 anchor bit");
        prog_check(0, "R7 sector 0 bottom");
        prog_check(longint'(NS - 1) * SB, "R3 reduced keeps top anchor");
        prog_check(longint'(1) * SB, "R7 first open sector");
        // R4: bp3 present / absent, R8 saturation
        wr_status(8'b0111_1100);
        rd_check(1'b0, "R4 bp3 bit");
        prog_check(longint'(NS - 1) * SB, "R8 level 15 bottom");
        wr_status(8'b0101_0000);
        prog_check(0, "R8 level 12 top sector 0");
        prog_check(longint'(NS - 1) * SB, "R8 level 12 last");
        // R5: level 0
        wr_status(8'b1000_0000);
        prog_check(longint'(NS - 1) * SB, "R5 level 0 open");
        prog_check(0, "R5 level 0 sector 0");

        // R11: program in same cycle as a status write uses old state
        @(negedge clk);
        wr_stat = 1'b1;
        wr_data = 8'b0000_1100;  // level 3, top
        prog_req = 1'b1;
        prog_addr = AW'(longint'(NS - 1) * SB);
        @(negedge clk);
        wr_stat = 1'b0;
        prog_req = 1'b0;
        check(ok_f && ok_m, "R11 old state used", {30'd0, ok_f, ok_m}, 32'd3);
        lock_f = 1'b0; lv_f = 4'd3; tb_f = 1'b0;
        lock_m = 1'b0; lv_m = 4'd3;
        prog_check(longint'(NS - 1) * SB, "R11 new state next");

        // random mix
        for (int i = 0; i < 200; i++) begin
            wr_status(8'($urandom));
            if (i % 4 == 0) rd_check(1'($urandom), "R1 R3 R4 random read");
            for (int j = 0; j < 4; j++) begin
                longint a;
                case ($urandom % 3)
                    0: a = longint'($urandom % 16) * SB + longint'($urandom % SB);
                    1: a = longint'(NS - 1 - ($urandom % 16)) * SB + longint'($urandom % SB);
                    default: a = longint'($urandom % (NS * SB));
                endcase
                prog_check(a, "R6 R7 R8 random program");
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule